// File: doc/BRIEF.md
# Dual-Mode Down-Counting Timer

This block is a single 32-bit timer channel that counts down by one on every clock while it is enabled. When the count reaches zero the channel flags a pending interrupt and restarts: in reload mode it restarts from a software-programmed load value, giving a periodic tick. In free-running mode it wraps to all-ones and keeps going. Software programs and observes the channel through a small register bus (address, write strobe, read strobe, write data, read data) and receives one level interrupt line.

The pending interrupt is acknowledged by reading the end-of-interrupt location, which returns zero. Dropping the enable bit stops the count and also discards any pending interrupt. A mask bit in the control register hides the pending flag from both the interrupt line and the status register without discarding it.

Top module: `downcount_timer`

## Requirements
- R1: After reset every readable location returns zero, the counter is stopped and `irq` is low.
- R2: Control bit 0 is the enable. Writing it to 1 while stopped makes the counter hold the load value (offset 0x00) in the first enabled cycle after the write, then count down by one per clock.
- R3: With control bit 1 set (reload mode), the clock edge at which the counter is at zero sets the pending flag and reloads the counter from the load register, so the period is load+1 cycles.
- R4: With control bit 1 clear (free-running mode), the clock edge at which the counter is at zero sets the pending flag and sets the counter to 0xFFFFFFFF.
- R5: Control bit 2 is the mask. `irq` and bit 0 of the status register (offset 0x10) equal pending AND NOT mask; masking does not discard the pending flag, so clearing the mask later shows it.
- R6: A read strobe at offset 0x0C returns zero and clears the pending flag at that clock edge; when a zero event happens at the same edge, the flag stays set.
- R7: Writing the control register (offset 0x08) with bit 0 clear stops the counter at that clock edge, holding its value, and clears the pending flag at that same edge.
- R8: Writing the load register while the counter runs does not alter the current count; the new value is used at the next reload.
- R9: The current value (offset 0x04) reads the counter; writes to offsets 0x04, 0x0C and 0x10 have no effect. The control register reads back bits 2:0 as written and zero above.
- R10: Writing the control register with bit 0 set while already running does not restart the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte offset of the accessed register |
| bus_wr | input | 1 | Write strobe, takes effect at the rising edge |
| bus_rd | input | 1 | Read strobe; enables read data and triggers read side effects |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address while the read strobe is high, else zero |
| irq | output | 1 | Level interrupt: pending flag and not masked |

## Verification
A wrong count shows at the current-value location within one cycle of the fault, and a wrong zero decision shows one cycle later as a wrong reload value and a wrongly set or missing interrupt. Pending-flag faults (a missed clear on disable or acknowledge, or a lost event when an acknowledge collides with a zero) show directly on `irq` at the next sample. Mask faults are exposed by hiding a pending flag and then unmasking it, which must raise `irq` at once without the counter restarting.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    // Byte offsets decoded on the register bus
    localparam int OFF_LOAD  = 0;
    localparam int OFF_VALUE = 4;
    localparam int OFF_CTRL  = 8;
    localparam int OFF_EOI   = 12;
    localparam int OFF_STAT  = 16;

    // Number of implemented control bits
    localparam int CTRL_BITS = 3;

    // Packed so that bit 0 = enable, bit 1 = reload mode, bit 2 = mask
    typedef struct packed {
        logic mask;
        logic reload_mode;
        logic en;
    } ctrl_t;

endpackage

// File: rtl/dtmr_regs.sv
module dtmr_regs
    import dtmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] load_val,
    output logic              stop_now
);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] load;
    } regs_t;

    regs_t rg_d, rg_q;
    logic  hit_ctrl;
    logic  hit_load;

    always_comb begin
        hit_ctrl = wr && (addr == ADDR_W'(OFF_CTRL));
        hit_load = wr && (addr == ADDR_W'(OFF_LOAD));
        rg_d     = rg_q;
        if (hit_load) begin
            rg_d.load = wdata;
        end
        if (hit_ctrl) begin
            rg_d.ctrl = ctrl_t'(wdata[CTRL_BITS-1:0]);
        end
        // A control write that drops the enable acts at this very edge
        stop_now = hit_ctrl && !wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign ctrl     = rg_q.ctrl;
    assign load_val = rg_q.load;

endmodule

// File: rtl/dtmr_core.sv
module dtmr_core
    import dtmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_t             ctrl,
    input  logic              stop_now,
    input  logic [DATA_W-1:0] load_val,
    input  logic              eoi_clr,
    output logic [DATA_W-1:0] count,
    output logic              pending,
    output logic              started
);

    localparam logic [DATA_W-1:0] WRAP_VAL = '1;
    localparam logic [DATA_W-1:0] ONE      = DATA_W'(1);

    typedef struct packed {
        logic              started;
        logic              pending;
        logic [DATA_W-1:0] count;
    } core_t;

    core_t cs_d, cs_q;
    logic  run;
    logic  at_zero;
    logic  zero_evt;

    always_comb begin
        run      = ctrl.en && !stop_now;
        at_zero  = (cs_q.count == '0);
        zero_evt = run && cs_q.started && at_zero;
        cs_d     = cs_q;
        if (!run) begin
            // Stopped: hold the count, forget the pending event
            cs_d.started = 1'b0;
            cs_d.pending = 1'b0;
        end else begin
            cs_d.started = 1'b1;
            if (!cs_q.started) begin
                cs_d.count = load_val;
            end else if (at_zero) begin
                cs_d.count = ctrl.reload_mode ? load_val : WRAP_VAL;
            end else begin
                cs_d.count = cs_q.count - ONE;
            end
            // A new zero event outranks an acknowledge at the same edge
            cs_d.pending = zero_evt || (cs_q.pending && !eoi_clr);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= '0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign count   = cs_q.count;
    assign pending = cs_q.pending;
    assign started = cs_q.started;

endmodule

// File: rtl/dtmr_rdmux.sv
module dtmr_rdmux
    import dtmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic [DATA_W-1:0] load_val,
    input  logic [DATA_W-1:0] count,
    input  ctrl_t             ctrl,
    input  logic              irq_line,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        if (rd) begin
            case (addr)
                ADDR_W'(OFF_LOAD):  rdata = load_val;
                ADDR_W'(OFF_VALUE): rdata = count;
                ADDR_W'(OFF_CTRL):  rdata = DATA_W'(ctrl);
                ADDR_W'(OFF_STAT):  rdata = DATA_W'(irq_line);
                default:            rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/downcount_timer.sv
module downcount_timer
    import dtmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] EOI_ADDR = ADDR_W'(OFF_EOI);

    ctrl_t             ctrl;
    logic              ctrl_en;
    logic              ctrl_mode;
    logic              ctrl_mask;
    logic [DATA_W-1:0] load_val;
    logic [DATA_W-1:0] count;
    logic              pending;
    logic              started;
    logic              stop_now;
    logic              eoi_clr;
    logic              irq_line;

    dtmr_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wr       (bus_wr),
        .wdata    (bus_wdata),
        .ctrl     (ctrl),
        .load_val (load_val),
        .stop_now (stop_now)
    );

    assign eoi_clr = bus_rd && (bus_addr == EOI_ADDR);

    dtmr_core #(
        .DATA_W (DATA_W)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl     (ctrl),
        .stop_now (stop_now),
        .load_val (load_val),
        .eoi_clr  (eoi_clr),
        .count    (count),
        .pending  (pending),
        .started  (started)
    );

    assign ctrl_en   = ctrl.en;
    assign ctrl_mode = ctrl.reload_mode;
    assign ctrl_mask = ctrl.mask;
    assign irq_line  = pending && !ctrl_mask;
    assign irq       = irq_line;

    dtmr_rdmux #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_rdmux (
        .addr     (bus_addr),
        .rd       (bus_rd),
        .load_val (load_val),
        .count    (count),
        .ctrl     (ctrl),
        .irq_line (irq_line),
        .rdata    (bus_rdata)
    );

endmodule

// File: rtl/dtmr_checker.sv
module dtmr_checker
    import dtmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic              ctrl_en,
    input logic              ctrl_mode,
    input logic              stop_now,
    input logic              started,
    input logic              pending,
    input logic [DATA_W-1:0] count,
    input logic [DATA_W-1:0] load_val
);

    localparam logic [DATA_W-1:0] ALL_ONES = '1;
    localparam logic [DATA_W-1:0] ONE      = DATA_W'(1);

    // R2: first enabled cycle takes the load value
    assert_first_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && !started && !stop_now) |=> (count == $past(load_val)));

    // R2: running and nonzero means a decrement by one
    assert_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && started && !stop_now && count != '0) |=> (count == $past(count) - ONE));

    // R3: reload mode restarts from the load register and flags the event
    assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && started && !stop_now && count == '0 && ctrl_mode)
        |=> (count == $past(load_val) && pending));

    // R4: free-running mode wraps to all-ones and flags the event
    assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && started && !stop_now && count == '0 && !ctrl_mode)
        |=> (count == ALL_ONES && pending));

    // R5: the interrupt line is only ever high on an enabled channel
    assert_irq_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctrl_en);

    // R6: acknowledge location reads as zero
    assert_eoi_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(OFF_EOI)) |-> (bus_rdata == '0));

    // R7: a stopped channel carries no pending event
    assert_stopped_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |-> !pending);

    // R7: a disabling write freezes the count
    assert_stop_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_now |=> $stable(count));

endmodule

bind downcount_timer dtmr_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .ctrl_en   (ctrl_en),
    .ctrl_mode (ctrl_mode),
    .stop_now  (stop_now),
    .started   (started),
    .pending   (pending),
    .count     (count),
    .load_val  (load_val)
);

// File: tb/downcount_timer_bench.sv
module downcount_timer_bench;

    localparam int A_LOAD  = 0;
    localparam int A_VALUE = 4;
    localparam int A_CTRL  = 8;
    localparam int A_EOI   = 12;
    localparam int A_STAT  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    downcount_timer u_downcount_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // Expected count n cycles after the first enabled cycle
    function automatic logic [31:0] exp_count(input logic [31:0] ld, input bit reload, input int n);
        longint l = longint'(ld);
        if (reload) return 32'(l - (longint'(n) % (l + 1)));
        if (longint'(n) <= l) return 32'(l - longint'(n));
        return 32'(64'hFFFFFFFF - (longint'(n) - l - 1));
    endfunction

    function automatic logic exp_pend(input logic [31:0] ld, input int n);
        return longint'(n) > longint'(ld);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input int a, input logic [31:0] d);
        bus_addr  = 5'(a);
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    // Read without a strobe at the edge: no side effect, no cycle used
    task automatic peek(input int a, output logic [31:0] d);
        bus_addr = 5'(a);
        bus_rd   = 1'b1;
        #2;
        d        = bus_rdata;
        bus_rd   = 1'b0;
    endtask

    // Acknowledge read: strobe held through one edge
    task automatic eoi_read(output logic [31:0] d);
        bus_addr = 5'(A_EOI);
        bus_rd   = 1'b1;
        #2;
        d        = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    // Stop, program, enable; returns in the first enabled cycle (n = 0)
    task automatic start(input logic [31:0] ld, input logic [31:0] ctrl_val);
        bus_write(A_CTRL, 32'h0);
        bus_write(A_LOAD, ld);
        bus_write(A_CTRL, ctrl_val);
        @(negedge clk);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] held;
        logic [31:0] ld;
        int          k;
        bit          um;

        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        peek(A_LOAD, v);  chk("R1 load", v, 32'h0);
        peek(A_VALUE, v); chk("R1 value", v, 32'h0);
        peek(A_CTRL, v);  chk("R1 ctrl", v, 32'h0);
        peek(A_STAT, v);  chk("R1 status", v, 32'h0);
        peek(A_EOI, v);   chk("R1 eoi", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R2: load then count down (reload mode, ctrl = 3)
        start(32'd5, 32'h3);
        peek(A_VALUE, v); chk("R2 first cycle", v, 32'd5);
        step(2);
        peek(A_VALUE, v); chk("R2 decrement", v, 32'd3);

        // R5/R10: masked free-run (ctrl = 5), L = 2
        start(32'd2, 32'h5);
        step(3);
        chk("R5 masked irq", {31'b0, irq}, 32'h0);
        peek(A_STAT, v); chk("R5 masked status", v, 32'h0);
        bus_write(A_CTRL, 32'h1);               // unmask, stay enabled, n = 4
        chk("R5 unmask shows pending", {31'b0, irq}, 32'h1);
        peek(A_STAT, v); chk("R5 status", v, 32'h1);
        peek(A_VALUE, v); chk("R10 no restart", v, exp_count(32'd2, 1'b0, 4));
        peek(A_VALUE, v); chk("R4 wrap value", v, 32'hFFFFFFFE);

        // R6: acknowledge, n = 5
        eoi_read(v); chk("R6 eoi reads zero", v, 32'h0);
        chk("R6 irq cleared", {31'b0, irq}, 32'h0);
        peek(A_STAT, v); chk("R6 status cleared", v, 32'h0);

        // R7: stop holds count
        peek(A_VALUE, held); chk("R7 before stop", held, exp_count(32'd2, 1'b0, 5));
        bus_write(A_CTRL, 32'h0);
        peek(A_VALUE, v); chk("R7 held at stop", v, held);
        step(5);
        peek(A_VALUE, v); chk("R7 still held", v, held);

        // R7: stop discards pending at the write edge
        start(32'd1, 32'h3);
        step(3);
        chk("R3 pending before stop", {31'b0, irq}, 32'h1);
        bus_write(A_CTRL, 32'h0);
        chk("R7 irq cleared by stop", {31'b0, irq}, 32'h0);
        peek(A_STAT, v); chk("R7 status cleared by stop", v, 32'h0);

        // R6/R3: acknowledge colliding with a zero event, L = 3 reload
        start(32'd3, 32'h3);
        step(7);                                 // n = 7, count 0
        peek(A_VALUE, v); chk("R3 at zero", v, 32'd0);
        eoi_read(v);                             // n = 8
        chk("R6 event wins over eoi", {31'b0, irq}, 32'h1);
        peek(A_VALUE, v); chk("R3 reload value", v, 32'd3);
        eoi_read(v);                             // n = 9
        chk("R6 plain eoi", {31'b0, irq}, 32'h0);

        // R8: load write while running, L = 4 reload
        start(32'd4, 32'h3);
        step(1);
        bus_write(A_LOAD, 32'd7);                // n = 2
        peek(A_VALUE, v); chk("R8 count untouched", v, 32'd2);
        step(3);                                 // n = 5
        peek(A_VALUE, v); chk("R8 new load used", v, 32'd7);
        step(1);
        peek(A_VALUE, v); chk("R8 counting from new", v, 32'd6);

        // R9: read-only and write-ignored locations
        bus_write(A_CTRL, 32'h0);
        peek(A_VALUE, held);
        bus_write(A_VALUE, 32'h1234);
        peek(A_VALUE, v); chk("R9 value write ignored", v, held);
        start(32'd0, 32'h1);                     // free-run, L = 0
        step(1);                                 // n = 1, pending
        bus_write(A_EOI, 32'h0);                 // n = 2
        chk("R9 eoi write ignored", {31'b0, irq}, 32'h1);
        bus_write(A_STAT, 32'h0);                // n = 3
        chk("R9 status write ignored", {31'b0, irq}, 32'h1);
        peek(A_VALUE, v); chk("R9 count", v, exp_count(32'd0, 1'b0, 3));
        bus_write(A_CTRL, 32'hFFFFFFFF);
        peek(A_CTRL, v); chk("R9 ctrl readback", v, 32'h7);
        bus_write(A_CTRL, 32'h0);

        // Random: R2 R3 R4 R5 over mixed loads, modes and waits
        for (int it = 0; it < 40; it++) begin
            ld = $urandom % 24;
            um = 1'($urandom % 2);
            k  = int'($urandom % 60);
            start(ld, um ? 32'h3 : 32'h1);
            step(k);
            peek(A_VALUE, v);
            chk(um ? "R3 random count" : "R4 random count", v, exp_count(ld, um, k));
            peek(A_STAT, v);
            chk("R5 random status", v, {31'b0, exp_pend(ld, k)});
            chk("R5 random irq", {31'b0, irq}, {31'b0, exp_pend(ld, k)});
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule